// File: doc/BRIEF.md
# Master-Track Period Counter with Verification

This block holds the absolute period count of a multi-track position encoder. Every zero crossing of the master track moves the count by one, up or down according to a direction bit, and the count wraps at its width. At start-up, or whenever the system asks for it, the count is loaded with an absolute period value that was computed elsewhere from the auxiliary tracks. The count is the position word that leaves the block, and it follows the master track on every cycle.

When a new absolute period has been computed, it arrives on a valid/ready stream input. Depending on a two-bit verification mode, the block compares its running count with that value. On a difference it raises a mismatch flag and adopts the computed value; on agreement it clears the flag. In both cases it pulses a compare-done strobe. In the speed-dependent mode, the comparison is skipped while an internal speed monitor reports overspeed. The monitor counts crossings over a fixed window of clock cycles. Comparison resumes once a later window is back at or under the threshold.

The computed-period stream has no real back-pressure except one rule: `calc_ready` drops in any cycle where `pre_stb` is high, because the preload owns the counter that cycle. A producer must hold `calc_valid` and `calc_period` until it sees valid and ready together. A transfer that the mode does not compare is still consumed.

Top module: `mtpc_top`

## Requirements
- R1: With neither a preload nor a reload, a cycle with `zc` high adds one to `count` when `zc_up` is 1 and subtracts one when `zc_up` is 0, modulo 2^CNT_W. A cycle with `zc` low leaves `count` unchanged.
- R2: `pre_stb` high loads `pre_val` into `count` at the next edge. This takes priority over crossings and reloads.
- R3: Verification mode 0 (off) never compares. `cmp_done` stays low, `mismatch` keeps its value, and the computed period does not touch `count`.
- R4: Mode 1 (speed-dependent) compares an accepted period only while overspeed is clear. Overspeed is decided at the last cycle of each window of WIN_LEN cycles. It is set when the crossings in that window, including the last cycle's, exceed `frq_thr`, and cleared when they are at or below it. The crossing tally saturates at 2^FRQ_W-1.
- R5: Modes 2 and 3 compare every accepted period.
- R6: A compare makes `cmp_done` high for exactly the following cycle. It sets `mismatch` to whether `count` differed from `calc_period`. On a difference, `count` takes `calc_period` at that edge, and a crossing in the same cycle is dropped.
- R7: `calc_ready` is the inverse of `pre_stb`. A period is accepted only in a cycle with `calc_valid` and `calc_ready` both high.
- R8: After reset, `count` is 0, `cmp_done` and `mismatch` are low, and overspeed is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zc | input | 1 | Master-track zero-crossing pulse, one cycle per crossing |
| zc_up | input | 1 | Direction of the crossing, 1 = count up |
| pre_stb | input | 1 | Preload strobe |
| pre_val | input | CNT_W | Preload period value |
| calc_valid | input | 1 | Computed absolute period valid |
| calc_ready | output | 1 | Block can accept a computed period |
| calc_period | input | CNT_W | Computed absolute period |
| frq_thr | input | FRQ_W | Crossings-per-window threshold |
| vmode | input | 2 | Verification mode: 0 off, 1 speed-dependent, 2/3 always |
| count | output | CNT_W | Absolute period count (position word) |
| cmp_done | output | 1 | One-cycle pulse after each compare |
| mismatch | output | 1 | Result of the most recent compare |

## Verification
The bench drives the count across the all-ones/zero boundary in both directions. A counter without proper modular arithmetic would saturate or step by the wrong amount there. It offers a mismatching period in mode 0 and while overspeed holds. A design that ignores the mode would pulse `cmp_done` and overwrite the count. It collides a preload with a valid period and a crossing with a reload. Wrong priorities show up as the wrong value in `count` or as a period accepted while `calc_ready` is low. It also runs a burst above the threshold followed by quiet windows. A monitor that never clears overspeed, or that decides at the wrong cycle, would then suppress a compare that should happen.

// File: rtl/mtpc_pkg.sv
package mtpc_pkg;
  typedef enum logic [1:0] {
    VM_OFF    = 2'd0,
    VM_SPEED  = 2'd1,
    VM_ALWAYS = 2'd2,
    VM_ALT    = 2'd3
  } vmode_e;
endpackage

// File: rtl/mtpc_counter.sv
module mtpc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zc,
  input  logic             zc_up,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             reload,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (load)    count <= load_val;
    else if (reload)  count <= reload_val;
    else if (zc)      count <= zc_up ? count + ONE : count - ONE;
  end

  // R2: preload wins
  p_preload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(load_val));
  // R6: reload adopts the computed value
  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !load) |=> count == $past(reload_val));
  // R1: no event, no motion
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !reload && !zc) |=> $stable(count));
endmodule

// File: rtl/mtpc_speed.sv
module mtpc_speed #(
  parameter int WIN_LEN = 32,
  parameter int FRQ_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zc,
  input  logic [FRQ_W-1:0] thr,
  output logic             overspeed
);
  localparam int WW = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
  localparam logic [WW-1:0]    WLAST = WW'(WIN_LEN - 1);
  localparam logic [FRQ_W-1:0] SAT   = '1;

  logic [WW-1:0]    wcnt;
  logic [FRQ_W-1:0] tally, tally_nx;

  always_comb begin
    tally_nx = tally;
    if (zc && tally != SAT) tally_nx = tally + FRQ_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt      <= '0;
      tally     <= '0;
      overspeed <= 1'b0;
    end else if (wcnt == WLAST) begin
      wcnt      <= '0;
      tally     <= '0;
      overspeed <= tally_nx > thr;
    end else begin
      wcnt  <= wcnt + WW'(1);
      tally <= tally_nx;
    end
  end

  // R4: the flag only moves at a window boundary
  p_flag_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wcnt != WLAST) |=> $stable(overspeed));
endmodule

// File: rtl/mtpc_verify.sv
module mtpc_verify
  import mtpc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  vmode_e           vmode,
  input  logic             overspeed,
  input  logic             take,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] period,
  output logic             reload,
  output logic             cmp_done,
  output logic             mismatch
);
  logic enabled, fire, differ;

  always_comb begin
    unique case (vmode)
      VM_OFF:   enabled = 1'b0;
      VM_SPEED: enabled = !overspeed;
      default:  enabled = 1'b1;
    endcase
  end

  assign fire   = take && enabled;
  assign differ = count != period;
  assign reload = fire && differ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_done <= 1'b0;
      mismatch <= 1'b0;
    end else begin
      cmp_done <= fire;
      if (fire) mismatch <= differ;
    end
  end

  // R3: no compare in mode off
  p_off_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_done |-> $past(vmode) != VM_OFF);
  // R4: no compare under overspeed in speed mode
  p_speed_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_done && $past(vmode) == VM_SPEED) |-> !$past(overspeed));
  // R6: flag only changes with a compare
  p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_done |-> $stable(mismatch));
endmodule

// File: rtl/mtpc_top.sv
module mtpc_top
  import mtpc_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int FRQ_W   = 8,
  parameter int WIN_LEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zc,
  input  logic             zc_up,
  input  logic             pre_stb,
  input  logic [CNT_W-1:0] pre_val,
  input  logic             calc_valid,
  output logic             calc_ready,
  input  logic [CNT_W-1:0] calc_period,
  input  logic [FRQ_W-1:0] frq_thr,
  input  logic [1:0]       vmode,
  output logic [CNT_W-1:0] count,
  output logic             cmp_done,
  output logic             mismatch
);
  logic overspeed, take, reload;

  assign calc_ready = !pre_stb;
  assign take       = calc_valid && calc_ready;

  mtpc_speed #(.WIN_LEN(WIN_LEN), .FRQ_W(FRQ_W)) u_speed (
    .clk(clk), .rst_n(rst_n), .zc(zc), .thr(frq_thr), .overspeed(overspeed)
  );

  mtpc_verify #(.CNT_W(CNT_W)) u_verify (
    .clk(clk), .rst_n(rst_n), .vmode(vmode_e'(vmode)), .overspeed(overspeed),
    .take(take), .count(count), .period(calc_period),
    .reload(reload), .cmp_done(cmp_done), .mismatch(mismatch)
  );

  mtpc_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .zc(zc), .zc_up(zc_up),
    .load(pre_stb), .load_val(pre_val),
    .reload(reload), .reload_val(calc_period), .count(count)
  );

  // R7: a refused period leads to no compare
  p_refused_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (calc_valid && !calc_ready) |=> !cmp_done);
  // R6: a compare strobe lasts one cycle per transfer
  p_done_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_done |-> $past(calc_valid && calc_ready));
endmodule

// File: tb/tb_mtpc_top.sv
module tb_mtpc_top;
  localparam int CLK_P = 10;
  localparam int W     = 16;
  localparam int THR   = 4;

  logic clk = 0, rst_n = 0;
  logic zc = 0, zc_up = 1, pre_stb = 0, calc_valid = 0;
  logic [15:0] pre_val = 0, calc_period = 0;
  logic [7:0] frq_thr = THR[7:0];
  logic [1:0] vmode = 0;
  logic calc_ready, cmp_done, mismatch;
  logic [15:0] count;

  int checks = 0, fails = 0;
  bit finished = 0;

  // reference state
  int m_cnt = 0, m_win = 0, m_cc = 0;
  bit m_done = 0, m_mis = 0, m_ovs = 0;

  mtpc_top #(.CNT_W(16), .FRQ_W(8), .WIN_LEN(W)) dut (
    .clk(clk), .rst_n(rst_n), .zc(zc), .zc_up(zc_up), .pre_stb(pre_stb),
    .pre_val(pre_val), .calc_valid(calc_valid), .calc_ready(calc_ready),
    .calc_period(calc_period), .frq_thr(frq_thr), .vmode(vmode),
    .count(count), .cmp_done(cmp_done), .mismatch(mismatch)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one clock: drive, predict, clock, compare
  task automatic step(input string tag, input bit z, input bit up, input bit ps,
                      input int pv, input bit cv, input int cp, input int md);
    bit rdy, take, en;
    int tally;
    zc = z; zc_up = up; pre_stb = ps; pre_val = pv[15:0];
    calc_valid = cv; calc_period = cp[15:0]; vmode = md[1:0];
    #1;
    rdy = !ps;
    chk("R7", "calc_ready", calc_ready, rdy);
    take = cv && rdy;
    en = take && (md >= 2 || (md == 1 && !m_ovs));
    m_done = en;
    if (en) m_mis = (m_cnt != cp);
    if (ps) m_cnt = pv;
    else if (en && m_cnt != cp) m_cnt = cp;
    else if (z) m_cnt = up ? (m_cnt + 1) % 65536 : (m_cnt + 65535) % 65536;
    tally = (z && m_cc < 255) ? m_cc + 1 : m_cc;
    if (m_win == W - 1) begin
      m_ovs = tally > THR; m_cc = 0; m_win = 0;
    end else begin
      m_cc = tally; m_win++;
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "count", count, m_cnt);
    chk(tag, "cmp_done", cmp_done, m_done);
    chk(tag, "mismatch", mismatch, m_mis);
  endtask

  task automatic idle(input string tag, input int n, input int md);
    for (int i = 0; i < n; i++) step(tag, 0, 1, 0, 0, 0, 0, md);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8", "count", count, 0);
    chk("R8", "cmp_done", cmp_done, 0);
    chk("R8", "mismatch", mismatch, 0);
    rst_n = 1;
    // R2 preload, then R1 counting and wrap
    step("R2", 0, 1, 1, 16'hFFFE, 0, 0, 0);
    step("R1", 1, 1, 0, 0, 0, 0, 0);
    step("R1", 1, 1, 0, 0, 0, 0, 0);
    chk("R1", "wrap up", count, 0);
    step("R1", 1, 0, 0, 0, 0, 0, 0);
    chk("R1", "wrap down", count, 16'hFFFF);
    step("R1", 0, 0, 0, 0, 0, 0, 0);
    // R3 mode off ignores a differing period
    step("R3", 0, 1, 0, 0, 1, 123, 0);
    chk("R3", "count kept", count, 16'hFFFF);
    // R5/R6 always mode: match, then mismatch with reload and dropped crossing
    step("R5", 0, 1, 1, 200, 0, 0, 2);
    step("R5", 0, 1, 0, 0, 1, 200, 2);
    chk("R6", "match flag", mismatch, 0);
    step("R6", 1, 1, 0, 0, 1, 300, 3);
    chk("R6", "reload", count, 300);
    chk("R6", "mismatch", mismatch, 1);
    step("R6", 0, 1, 0, 0, 0, 0, 3);
    chk("R6", "one-cycle done", cmp_done, 0);
    // R7 preload collides with valid period
    step("R7", 0, 1, 1, 50, 1, 999, 2);
    chk("R7", "preload wins", count, 50);
    chk("R7", "no compare", cmp_done, 0);
    // R4 speed mode: slow, burst, recovery
    idle("R4", 40, 1);
    step("R4", 0, 1, 0, 0, 1, 60, 1);
    chk("R4", "slow compare", cmp_done, 1);
    for (int i = 0; i < 2 * W; i++) step("R4", 1, 1, 0, 0, 0, 0, 1);
    step("R4", 0, 1, 0, 0, 1, 7, 1);
    chk("R4", "suppressed", cmp_done, 0);
    idle("R4", 2 * W, 1);
    step("R4", 0, 1, 0, 0, 1, 7, 1);
    chk("R4", "resumed", cmp_done, 1);
    // R4 threshold boundary: exactly THR crossings in a window stay slow
    idle("R4", W, 1);
    for (int i = 0; i < 3 * W; i++) step("R4", (i % W) < THR, 0, 0, 0, 0, 0, 1);
    step("R4", 0, 1, 0, 0, 1, 9, 1);
    chk("R4", "at threshold", cmp_done, 1);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule